// File: doc/BRIEF.md
# NVRAM Header Checksum Sequencer

This block computes a 16-bit checksum over a range of a byte-wide non-volatile memory and stores the result back into that memory. A one-cycle start request supplies a base address and a byte count. The sequencer then reads the range through a synchronous read port that returns data one cycle after the address. It folds 16-bit big-endian words into a running value with a nibble-based shift-and-XOR step. Finally it writes the 16-bit result as two bytes at a fixed location and pulses a completion flag.

The words overlap. The word for index i is built from the bytes at base+i and base+i+1, and i advances by one byte at a time across the even part of the count. When the count is odd, one more step folds the trailing byte, placed in the upper half of a word whose lower half is zero. The memory itself sits outside the block. The sequencer only drives the address, the read and write enables, and the write data. Addresses wrap modulo the address width.

Top module: `nvcsum_engine`

## Requirements
- R1: After reset `busy` and `donePulse` are 0, `memRdEn` and `memWrEn` are 0, and `csumOut` reads 0xFFFF.
- R2: A `startPulse` while idle captures `startAddr` and `byteCount`. It restarts the running value at 0xFFFF, and `busy` is 1 from the next cycle.
- R3: One fold step with running value p and word v computes d = p^v, a = d[3:0] and b = d[7:4]^a. The new value is (p>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), kept to 16 bits.
- R4: With E = `byteCount` with bit 0 cleared, E steps run for i = 0..E-1. Each uses the word {mem[base+i], mem[base+i+1]}, with the first byte as the upper 8 bits.
- R5: When bit 0 of `byteCount` is 1, one final step uses {mem[base+E], 8'h00}.
- R6: A count of 0 performs no fold. It still writes back 0xFFFF and pulses `donePulse`.
- R7: The write-back takes two consecutive write cycles. The first writes the upper byte at RESULT_ADDR and the second writes the lower byte at RESULT_ADDR+1.
- R8: `donePulse` is high for exactly one cycle, in the cycle after the second write. `csumOut` then holds the result until the next accepted start.
- R9: A `startPulse` while `busy` is 1 has no effect. The running operation finishes with its own range and no further operation follows.
- R10: Reads and writes never occur in the same cycle. Each byte is read separately, one per cycle, with its data sampled one cycle later. `donePulse` appears 3 + 3·E + 2·(count bit 0) clock edges after the edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request to begin an operation |
| startAddr | input | AW | First byte address of the range |
| byteCount | input | CW | Number of bytes covered |
| memRdData | input | 8 | Read data, valid one cycle after the read request |
| memAddr | output | AW | Memory address for a read or write |
| memRdEn | output | 1 | Read request |
| memWrEn | output | 1 | Write request |
| memWrData | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-cycle completion flag |
| csumOut | output | 16 | Current or final checksum value |

## Verification
Every result has a latency fixed by the count. `busy` rises one edge after the accepting edge. `donePulse` and the final `csumOut` arrive exactly 3 + 3·E + 2·odd edges after it, and the two stored bytes are already in memory when `donePulse` is seen. The driver records the accepting cycle with each expected checksum. The monitor samples on the falling edge, compares the done cycle against that exact edge count, and checks the value and the stored bytes in the same cycle. One cycle later the driver checks that `donePulse` has dropped and that the value holds.

// File: rtl/nvcsum_pkg.sv
package nvcsum_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_RD_HI, ST_RD_LO, ST_FOLD,
    ST_ODD_RD, ST_ODD_FOLD, ST_WR_HI, ST_WR_LO, ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOp;
    logic rdHi;
    logic rdLo;
    logic rdOdd;
    logic latchHi;
    logic foldWord;
    logic foldOdd;
    logic wrHi;
    logic wrLo;
  } ctlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic anyWords;
    logic moreWords;
    logic oddTail;
  } dpStatus_t;

  function automatic logic [15:0] foldStep(input logic [15:0] prev, input logic [15:0] word);
    logic [15:0] mix;
    logic [3:0]  lowNib;
    logic [3:0]  highNib;
    logic [15:0] lowExt;
    logic [15:0] highExt;
    mix     = prev ^ word;
    lowNib  = mix[3:0];
    highNib = mix[7:4] ^ lowNib;
    lowExt  = {12'h000, lowNib};
    highExt = {12'h000, highNib};
    foldStep = (prev >> 8) ^ (lowExt << 3) ^ (lowExt << 8)
             ^ highExt ^ (highExt << 7) ^ (highExt << 12);
  endfunction

endpackage

// File: rtl/nvcsum_ctrl.sv
module nvcsum_ctrl
  import nvcsum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        donePulse
);

  seqState_t state;
  seqState_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobes.loadOp = 1'b1;
          stateNext      = ST_ARM;
        end
      end
      ST_ARM: begin
        if (status.anyWords)     stateNext = ST_RD_HI;
        else if (status.oddTail) stateNext = ST_ODD_RD;
        else                     stateNext = ST_WR_HI;
      end
      ST_RD_HI: begin
        strobes.rdHi = 1'b1;
        stateNext    = ST_RD_LO;
      end
      ST_RD_LO: begin
        strobes.rdLo    = 1'b1;
        strobes.latchHi = 1'b1;
        stateNext       = ST_FOLD;
      end
      ST_FOLD: begin
        strobes.foldWord = 1'b1;
        if (status.moreWords)    stateNext = ST_RD_HI;
        else if (status.oddTail) stateNext = ST_ODD_RD;
        else                     stateNext = ST_WR_HI;
      end
      ST_ODD_RD: begin
        strobes.rdOdd = 1'b1;
        stateNext     = ST_ODD_FOLD;
      end
      ST_ODD_FOLD: begin
        strobes.foldOdd = 1'b1;
        stateNext       = ST_WR_HI;
      end
      ST_WR_HI: begin
        strobes.wrHi = 1'b1;
        stateNext    = ST_WR_LO;
      end
      ST_WR_LO: begin
        strobes.wrLo = 1'b1;
        stateNext    = ST_DONE;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign donePulse = (state == ST_DONE);

endmodule

// File: rtl/nvcsum_dp.sv
module nvcsum_dp
  import nvcsum_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CW          = 8,
  parameter int RESULT_ADDR = 'hFC
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] byteCount,
  input  logic [7:0]    memRdData,
  output dpStatus_t     status,
  output logic [AW-1:0] memAddr,
  output logic          memRdEn,
  output logic          memWrEn,
  output logic [7:0]    memWrData,
  output logic [15:0]   csumOut
);

  localparam logic [AW-1:0] WB_HI = AW'(RESULT_ADDR);
  localparam logic [AW-1:0] WB_LO = AW'(RESULT_ADDR + 1);

  logic [AW-1:0] baseAddr;
  logic [CW-1:0] countReg;
  logic [CW-1:0] idx;
  logic [7:0]    hiByte;
  logic [15:0]   csum;
  logic [CW-1:0] evenPart;
  logic [AW-1:0] curAddr;

  assign evenPart = {countReg[CW-1:1], 1'b0};
  assign curAddr  = baseAddr + AW'(idx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      countReg <= '0;
      idx      <= '0;
      hiByte   <= '0;
      csum     <= 16'hFFFF;
    end else begin
      if (strobes.loadOp) begin
        baseAddr <= startAddr;
        countReg <= byteCount;
        idx      <= '0;
        csum     <= 16'hFFFF;
      end
      if (strobes.latchHi)  hiByte <= memRdData;
      if (strobes.foldWord) begin
        csum <= foldStep(csum, {hiByte, memRdData});
        idx  <= idx + 1'b1;
      end
      if (strobes.foldOdd)  csum <= foldStep(csum, {memRdData, 8'h00});
    end
  end

  assign status.anyWords  = (evenPart != '0);
  assign status.moreWords = ({1'b0, idx} + 1'b1) < {1'b0, evenPart};
  assign status.oddTail   = countReg[0];

  always_comb begin
    memAddr = curAddr;
    if (strobes.rdLo)      memAddr = curAddr + 1'b1;
    else if (strobes.wrHi) memAddr = WB_HI;
    else if (strobes.wrLo) memAddr = WB_LO;
  end

  assign memRdEn   = strobes.rdHi | strobes.rdLo | strobes.rdOdd;
  assign memWrEn   = strobes.wrHi | strobes.wrLo;
  assign memWrData = strobes.wrHi ? csum[15:8] : csum[7:0];
  assign csumOut   = csum;

endmodule

// File: rtl/nvcsum_engine.sv
module nvcsum_engine
  import nvcsum_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CW          = 8,
  parameter int RESULT_ADDR = 'hFC
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] byteCount,
  input  logic [7:0]    memRdData,
  output logic [AW-1:0] memAddr,
  output logic          memRdEn,
  output logic          memWrEn,
  output logic [7:0]    memWrData,
  output logic          busy,
  output logic          donePulse,
  output logic [15:0]   csumOut
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  nvcsum_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .status    (status),
    .strobes   (strobes),
    .busy      (busy),
    .donePulse (donePulse)
  );

  nvcsum_dp #(.AW(AW), .CW(CW), .RESULT_ADDR(RESULT_ADDR)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startAddr(startAddr),
    .byteCount(byteCount),
    .memRdData(memRdData),
    .status   (status),
    .memAddr  (memAddr),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn),
    .memWrData(memWrData),
    .csumOut  (csumOut)
  );

endmodule

// File: rtl/nvcsum_engine_chk.sv
module nvcsum_engine_chk #(
  parameter int AW          = 8,
  parameter int CW          = 8,
  parameter int RESULT_ADDR = 'hFC
) (
  input logic          clk,
  input logic          rstN,
  input logic          startPulse,
  input logic [CW-1:0] byteCount,
  input logic [AW-1:0] memAddr,
  input logic          memRdEn,
  input logic          memWrEn,
  input logic [7:0]    memWrData,
  input logic          busy,
  input logic          donePulse,
  input logic [15:0]   csumOut
);

  localparam logic [AW-1:0] WB_HI = AW'(RESULT_ADDR);
  localparam logic [AW-1:0] WB_LO = AW'(RESULT_ADDR + 1);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy);

  assert_zero_writes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse && byteCount == '0) |=> ##1 (memWrEn && memAddr == WB_HI));

  assert_wb_pair_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && memAddr == WB_HI) |=> (memWrEn && memAddr == WB_LO));

  assert_wb_hi_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && memAddr == WB_HI) |-> (memWrData == csumOut[15:8]));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_done_after_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ($past(memWrEn) && $past(memAddr) == WB_LO));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> $stable(csumOut));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !donePulse && startPulse) |=> busy);

  assert_no_rw_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !memWrEn));

endmodule

bind nvcsum_engine nvcsum_engine_chk #(.AW(AW), .CW(CW), .RESULT_ADDR(RESULT_ADDR)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .byteCount (byteCount),
  .memAddr   (memAddr),
  .memRdEn   (memRdEn),
  .memWrEn   (memWrEn),
  .memWrData (memWrData),
  .busy      (busy),
  .donePulse (donePulse),
  .csumOut   (csumOut)
);

// File: tb/nvcsum_engine_bench.sv
`timescale 1ns/1ps
module nvcsum_engine_bench;

  localparam int AW = 8;
  localparam int CW = 8;
  localparam int RES = 'hFC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [CW-1:0] byteCount = '0;
  logic [7:0]    memRdData;
  logic [AW-1:0] memAddr;
  logic          memRdEn, memWrEn, busy, donePulse;
  logic [7:0]    memWrData;
  logic [15:0]   csumOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] mem [256];

  logic [15:0] csumQ [$];
  int          dueQ  [$];
  string       tagQ  [$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model: registered read, one cycle latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) mem[memAddr] <= memWrData;
  end

  nvcsum_engine #(.AW(AW), .CW(CW), .RESULT_ADDR(RES)) u_nvcsum_engine (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(startAddr),
    .byteCount(byteCount), .memRdData(memRdData), .memAddr(memAddr),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData),
    .busy(busy), .donePulse(donePulse), .csumOut(csumOut));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] refStep(input logic [15:0] p, input logic [15:0] v);
    logic [7:0] d;
    logic [3:0] a, b;
    d = p[7:0] ^ v[7:0];
    a = d[3:0];
    b = d[7:4] ^ a;
    refStep = {8'h00, p[15:8]} ^ {9'b0, a, 3'b0} ^ {4'b0, a, 8'b0}
            ^ {12'b0, b} ^ {5'b0, b, 7'b0} ^ {b, 12'b0};
  endfunction

  function automatic logic [15:0] refSum(input logic [7:0] a, input int n);
    logic [15:0] c;
    int e;
    c = 16'hFFFF;
    e = n & ~1;
    for (int i = 0; i < e; i++)
      c = refStep(c, {mem[8'(a + i)], mem[8'(a + i + 1)]});
    if (n % 2 == 1) c = refStep(c, {mem[8'(a + e)], 8'h00});
    return c;
  endfunction

  // driver: pushes expectation, pulses start, optionally a stray start while busy
  task automatic runOp(input logic [7:0] a, input int n, input string tag,
                       input bit stray);
    logic [15:0] exp;
    int lat;
    exp = refSum(a, n);
    lat = 3 + 3 * (n & ~1) + 2 * (n % 2);
    @(negedge clk);
    startAddr  = a;
    byteCount  = CW'(n);
    startPulse = 1'b1;
    csumQ.push_back(exp);
    dueQ.push_back(cyc + 1 + lat);
    tagQ.push_back(tag);
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (stray) begin
      @(negedge clk);
      startAddr  = 8'h80;
      byteCount  = 8'd5;
      startPulse = 1'b1;     // R9: must be ignored
      @(negedge clk);
      startPulse = 1'b0;
    end
    while (!donePulse) @(negedge clk);
    @(negedge clk);
    check(donePulse == 1'b0, "R8", "done one cycle", donePulse, 0);
    check(busy == 1'b0, "R9", "idle after op", busy, 0);
    repeat (6) @(negedge clk);
    check(csumOut == exp, "R8", "value held", csumOut, exp);
    check(busy == 1'b0, "R9", "no second op", busy, 0);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && donePulse) begin
        if (csumQ.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          logic [15:0] e;
          int d;
          string t;
          e = csumQ.pop_front();
          d = dueQ.pop_front();
          t = tagQ.pop_front();
          check(csumOut == e, t, "checksum", csumOut, e);
          check(cyc == d, "R10", "done latency", cyc, d);
          check(mem[8'(RES)] == e[15:8], "R7", "stored high byte", mem[8'(RES)], e[15:8]);
          check(mem[8'(RES + 1)] == e[7:0], "R7", "stored low byte", mem[8'(RES + 1)], e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy at reset", busy, 0);
    check(donePulse == 1'b0, "R1", "done at reset", donePulse, 0);
    check(!memRdEn && !memWrEn, "R1", "enables at reset", {memRdEn, memWrEn}, 0);
    check(csumOut == 16'hFFFF, "R1", "value at reset", csumOut, 16'hFFFF);
    rstN = 1'b1;
    @(negedge clk);
    runOp(8'h10, 0,    "R6", 1'b0);
    runOp(8'h20, 1,    "R5", 1'b0);
    runOp(8'h20, 2,    "R4", 1'b0);
    runOp(8'h31, 3,    "R5", 1'b0);
    runOp(8'h40, 7,    "R3", 1'b0);
    runOp(8'h00, 'hF8, "R4", 1'b0);
    runOp(8'hF0, 20,   "R4", 1'b0);
    runOp(8'h50, 9,    "R9", 1'b1);
    mem[8'h60] = 8'hFF; mem[8'h61] = 8'h00; mem[8'h62] = 8'hA5;
    runOp(8'h60, 3,    "R3", 1'b0);
    repeat (4) @(negedge clk);
    check(csumQ.size() == 0, "R8", "pending results", csumQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule